// File: doc/BRIEF.md
# DMA Channel Termination and Error Status Controller

This block runs the transfer of the single DMA channel that is currently active, one 32-bit word at a time. Each iteration is one bus read followed by one bus write. A start command loads a channel number, an iteration count and the source and destination addresses. The controller then alternates between read and write requests on a simple request/acknowledge bus. After each accepted access it advances the addresses, and after each write it counts the iteration down. The current source address, destination address and iteration count are always visible as the channel's descriptor state.

Most of the logic handles abnormal endings. A bus error, a software cancel or an error cancel each stop the channel at a defined point. The rules that set the stopping point are:

- An erroring read is still followed by its write, which uses the data captured from that read.
- An erroring write is still followed by the next read, if one is due.
- A cancel lets the current read-write pair finish.
- A cancel arriving during the final pair is dropped.

When the channel halts on an error, the error status register captures the channel number, the error kind and a valid flag. The channel's bit in a per-channel error vector is set and the error interrupt goes high. Both stay until software clears them with a strobe.

Top module: `dma_term_ctrl`

## Requirements
- R1: After reset the channel is idle: no read or write request, busy and done low, error status valid low, all per-channel error bits low, error interrupt low.
- R2: A start with a non-zero count while not busy loads the channel, the addresses and the count, then performs read, write, read, write and so on. Each accepted read adds 4 to the source address and captures the read data. Each accepted write adds 4 to the destination address, drives the captured data and decrements the count. When the count reaches zero the channel retires and done goes high; done is high only after normal retirement.
- R3: A read acknowledged with the error flag sets the source-error flag. The following write still executes with the data captured on that read, and the channel then halts without retiring.
- R4: A write acknowledged with the error flag sets the destination-error flag. If iterations remain, exactly one more read executes and the channel then halts. On the final write it halts at once.
- R5: At a halt, the descriptor outputs hold the source address, destination address and count as they stood after the last completed access.
- R6: A software cancel seen during a read-write pair that is not the last one lets that pair finish. The channel then goes idle with done low and leaves the error status untouched.
- R7: A cancel (either kind) seen while the count is 1 is discarded, and the channel retires normally with done high.
- R8: An error cancel stops the channel at the same point as a software cancel. It then halts, loads the channel number into the status register, sets the error-cancel and valid flags with both bus-error flags clear, and raises the error interrupt.
- R9: At every halt, the status register is loaded in the same cycle with the channel number, the source-error, destination-error and error-cancel flags, and valid set. The per-channel error bit of that channel is set, and the error interrupt equals the valid flag.
- R10: The status register contents and the error bits hold until the clear strobe, which drops valid and all error bits. A halt in the same cycle as the strobe still sets valid and its own channel bit.
- R11: A start while busy has no effect on the running transfer, and a start with count zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command |
| chan_i | input | CHW | Channel number for the start |
| count_i | input | CW | Iteration count for the start |
| src_i | input | AW | Start source address |
| dst_i | input | AW | Start destination address |
| cancel_i | input | 1 | Software cancel request |
| ecancel_i | input | 1 | Error cancel request |
| es_clr_i | input | 1 | Write-one-to-clear strobe for status valid and error bits |
| rd_req_o | output | 1 | Bus read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_err_i | input | 1 | Read error, qualified by acknowledge |
| rd_data_i | input | DW | Read data, qualified by acknowledge |
| wr_req_o | output | 1 | Bus write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write error, qualified by acknowledge |
| cur_src_o | output | AW | Descriptor: current source address |
| cur_dst_o | output | AW | Descriptor: current destination address |
| cur_cnt_o | output | CW | Descriptor: current iteration count |
| busy_o | output | 1 | Channel reading or writing |
| done_o | output | 1 | Channel retired normally |
| err_bits_o | output | NCH | Per-channel error bits |
| es_chan_o | output | CHW | Status: channel that halted |
| es_sbe_o | output | 1 | Status: source bus error |
| es_dbe_o | output | 1 | Status: destination bus error |
| es_ecx_o | output | 1 | Status: error cancel |
| es_vld_o | output | 1 | Status: valid |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The transfer is run with three patterns:

- Error-free transfers at zero and two cycles of bus latency, to confirm the address and count stepping and retirement.
- Injected read errors and write errors at a middle iteration and at the final iteration. These tell the write-after-read-error rule apart from the read-after-write-error rule, and show where the halt lands on the last write.
- Cancels, error cancels and extra starts, each pulsed while a chosen count is showing. These separate a cancel honoured after its pair from one dropped on the final pair, and show that a busy channel ignores a new start.

A behavioural model predicts every output on every cycle. Each run also ends with checks on the final descriptor values and the status fields.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE,
    ST_HALT_ERR
  } chan_st_e;
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int CHW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [CHW-1:0] chan_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic           rd_fire_i,
  input  logic [DW-1:0]  rd_data_i,
  input  logic           wr_fire_i,
  output logic [CHW-1:0] chan_o,
  output logic [CW-1:0]  cnt_o,
  output logic [AW-1:0]  src_o,
  output logic [AW-1:0]  dst_o,
  output logic [DW-1:0]  data_o
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o <= '0;
      cnt_o  <= '0;
      src_o  <= '0;
      dst_o  <= '0;
      data_o <= '0;
    end else if (load_i) begin
      chan_o <= chan_i;
      cnt_o  <= cnt_i;
      src_o  <= src_i;
      dst_o  <= dst_i;
      data_o <= '0;
    end else begin
      if (rd_fire_i) begin
        src_o  <= src_o + STEP;
        data_o <= rd_data_i;
      end
      if (wr_fire_i) begin
        dst_o <= dst_o + STEP;
        cnt_o <= cnt_o - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_term_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rd_ack_i,
  input  logic          rd_err_i,
  input  logic          wr_ack_i,
  input  logic          wr_err_i,
  input  logic          cancel_i,
  input  logic          ecancel_i,
  output chan_st_e      state_o,
  output logic          load_o,
  output logic          rd_fire_o,
  output logic          wr_fire_o,
  output logic          halt_o,
  output logic          halt_sbe_o,
  output logic          halt_dbe_o,
  output logic          halt_ecx_o
);
  chan_st_e st_q, st_n;
  logic sbe_q, sbe_n, dbe_q, dbe_n, cx_q, cx_n, ecx_q, ecx_n, trail_q, trail_n;
  logic active, last_pair, eff_cx, eff_ecx;

  assign active    = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign last_pair = (cnt_i == CW'(1));
  // cancels on the final pair are dropped at arrival
  assign eff_cx    = cx_q | (cancel_i & ~last_pair);
  assign eff_ecx   = ecx_q | (ecancel_i & ~last_pair);
  assign load_o    = !active && start_i && (count_i != '0);
  assign rd_fire_o = (st_q == ST_READ) && rd_ack_i;
  assign wr_fire_o = (st_q == ST_WRITE) && wr_ack_i;
  assign state_o   = st_q;

  always_comb begin
    st_n       = st_q;
    sbe_n      = sbe_q;
    dbe_n      = dbe_q;
    cx_n       = cx_q;
    ecx_n      = ecx_q;
    trail_n    = trail_q;
    halt_o     = 1'b0;
    halt_sbe_o = sbe_q;
    halt_dbe_o = dbe_q;
    halt_ecx_o = 1'b0;
    if (active) begin
      cx_n  = eff_cx;
      ecx_n = eff_ecx;
    end
    case (st_q)
      ST_READ: begin
        if (rd_ack_i) begin
          sbe_n = sbe_q | rd_err_i;
          if (trail_q) begin
            halt_o     = 1'b1;
            halt_sbe_o = sbe_n;
            st_n       = ST_HALT_ERR;
          end else begin
            st_n = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (wr_ack_i) begin
          dbe_n = dbe_q | wr_err_i;
          if (sbe_q || wr_err_i) begin
            if (wr_err_i && !sbe_q && !last_pair) begin
              trail_n = 1'b1;   // one pipelined read still runs
              st_n    = ST_READ;
            end else begin
              halt_o     = 1'b1;
              halt_dbe_o = dbe_n;
              st_n       = ST_HALT_ERR;
            end
          end else if (last_pair) begin
            st_n = ST_DONE;
          end else if (eff_ecx) begin
            halt_o     = 1'b1;
            halt_ecx_o = 1'b1;
            st_n       = ST_HALT_ERR;
          end else if (eff_cx) begin
            st_n = ST_IDLE;
          end else begin
            st_n = ST_READ;
          end
        end
      end
      default: ;
    endcase
    if (load_o) begin
      st_n    = ST_READ;
      sbe_n   = 1'b0;
      dbe_n   = 1'b0;
      cx_n    = 1'b0;
      ecx_n   = 1'b0;
      trail_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sbe_q   <= 1'b0;
      dbe_q   <= 1'b0;
      cx_q    <= 1'b0;
      ecx_q   <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      sbe_q   <= sbe_n;
      dbe_q   <= dbe_n;
      cx_q    <= cx_n;
      ecx_q   <= ecx_n;
      trail_q <= trail_n;
    end
  end
endmodule

// File: rtl/dma_err_status.sv
module dma_err_status #(
  parameter int NCH = 16,
  parameter int CHW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [CHW-1:0] chan_i,
  input  logic           sbe_i,
  input  logic           dbe_i,
  input  logic           ecx_i,
  input  logic           clr_i,
  output logic [NCH-1:0] err_bits_o,
  output logic [CHW-1:0] es_chan_o,
  output logic           es_sbe_o,
  output logic           es_dbe_o,
  output logic           es_ecx_o,
  output logic           es_vld_o
);
  logic [NCH-1:0] bits_n;

  always_comb begin
    bits_n = clr_i ? '0 : err_bits_o;
    if (load_i) bits_n = bits_n | (NCH'(1) << chan_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_bits_o <= '0;
      es_chan_o  <= '0;
      es_sbe_o   <= 1'b0;
      es_dbe_o   <= 1'b0;
      es_ecx_o   <= 1'b0;
      es_vld_o   <= 1'b0;
    end else begin
      err_bits_o <= bits_n;
      if (load_i) begin
        es_chan_o <= chan_i;
        es_sbe_o  <= sbe_i;
        es_dbe_o  <= dbe_i;
        es_ecx_o  <= ecx_i;
        es_vld_o  <= 1'b1;
      end else if (clr_i) begin
        es_vld_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [CHW-1:0] chan_i,
  input  logic [CW-1:0]  count_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic           cancel_i,
  input  logic           ecancel_i,
  input  logic           es_clr_i,
  output logic           rd_req_o,
  output logic [AW-1:0]  rd_addr_o,
  input  logic           rd_ack_i,
  input  logic           rd_err_i,
  input  logic [DW-1:0]  rd_data_i,
  output logic           wr_req_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  input  logic           wr_ack_i,
  input  logic           wr_err_i,
  output logic [AW-1:0]  cur_src_o,
  output logic [AW-1:0]  cur_dst_o,
  output logic [CW-1:0]  cur_cnt_o,
  output logic           busy_o,
  output logic           done_o,
  output logic [NCH-1:0] err_bits_o,
  output logic [CHW-1:0] es_chan_o,
  output logic           es_sbe_o,
  output logic           es_dbe_o,
  output logic           es_ecx_o,
  output logic           es_vld_o,
  output logic           err_irq_o
);
  chan_st_e       st;
  logic           load, rd_fire, wr_fire, halt, h_sbe, h_dbe, h_ecx;
  logic [CHW-1:0] act_chan;
  logic [DW-1:0]  data;

  dma_xfer_fsm #(.CW(CW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .count_i    (count_i),
    .cnt_i      (cur_cnt_o),
    .rd_ack_i   (rd_ack_i),
    .rd_err_i   (rd_err_i),
    .wr_ack_i   (wr_ack_i),
    .wr_err_i   (wr_err_i),
    .cancel_i   (cancel_i),
    .ecancel_i  (ecancel_i),
    .state_o    (st),
    .load_o     (load),
    .rd_fire_o  (rd_fire),
    .wr_fire_o  (wr_fire),
    .halt_o     (halt),
    .halt_sbe_o (h_sbe),
    .halt_dbe_o (h_dbe),
    .halt_ecx_o (h_ecx)
  );

  dma_desc_regs #(.AW(AW), .DW(DW), .CW(CW), .CHW(CHW)) u_desc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .chan_i    (chan_i),
    .cnt_i     (count_i),
    .src_i     (src_i),
    .dst_i     (dst_i),
    .rd_fire_i (rd_fire),
    .rd_data_i (rd_data_i),
    .wr_fire_i (wr_fire),
    .chan_o    (act_chan),
    .cnt_o     (cur_cnt_o),
    .src_o     (cur_src_o),
    .dst_o     (cur_dst_o),
    .data_o    (data)
  );

  dma_err_status #(.NCH(NCH), .CHW(CHW)) u_es (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (halt),
    .chan_i     (act_chan),
    .sbe_i      (h_sbe),
    .dbe_i      (h_dbe),
    .ecx_i      (h_ecx),
    .clr_i      (es_clr_i),
    .err_bits_o (err_bits_o),
    .es_chan_o  (es_chan_o),
    .es_sbe_o   (es_sbe_o),
    .es_dbe_o   (es_dbe_o),
    .es_ecx_o   (es_ecx_o),
    .es_vld_o   (es_vld_o)
  );

  assign rd_req_o  = (st == ST_READ);
  assign wr_req_o  = (st == ST_WRITE);
  assign rd_addr_o = cur_src_o;
  assign wr_addr_o = cur_dst_o;
  assign wr_data_o = data;
  assign busy_o    = rd_req_o | wr_req_o;
  assign done_o    = (st == ST_DONE);
  assign err_irq_o = es_vld_o;
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           rd_req_o,
  input logic           rd_ack_i,
  input logic           rd_err_i,
  input logic           wr_req_o,
  input logic           wr_ack_i,
  input logic [AW-1:0]  cur_dst_o,
  input logic [CW-1:0]  cur_cnt_o,
  input logic           busy_o,
  input logic [NCH-1:0] err_bits_o,
  input logic [CHW-1:0] es_chan_o,
  input logic           es_vld_o,
  input logic           es_clr_i
);
  // R2
  dst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ack_i) |=> (cur_dst_o == $past(cur_dst_o) + AW'(4)));

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ack_i) |=> (cur_cnt_o == $past(cur_cnt_o) - CW'(1)));

  // R2
  rd_leaves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i) |=> !rd_req_o);

  // R3
  rd_err_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i && rd_err_i) |=> (wr_req_o || es_vld_o));

  // R9
  es_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(es_vld_o) |-> err_bits_o[es_chan_o]);

  // R10
  es_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (es_vld_o && !es_clr_i) |=> es_vld_o);

  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !(wr_req_o && wr_ack_i)) |=> $stable(cur_cnt_o));
endmodule

bind dma_term_ctrl dma_term_chk #(.AW(AW), .CW(CW), .NCH(NCH)) u_chk (.*);

// File: tb/tb_dma_term_ctrl.sv
module tb_dma_term_ctrl;
  localparam int AW = 32, DW = 32, CW = 16, NCH = 16, CHW = 4;

  logic clk = 0, rst_n = 0;
  logic start = 0, cancel = 0, ecancel = 0, es_clr = 0;
  logic [CHW-1:0] chan = 0;
  logic [CW-1:0] count = 0;
  logic [AW-1:0] src = 0, dst = 0;
  logic rd_ack = 0, rd_err = 0, wr_ack = 0, wr_err = 0;
  logic [DW-1:0] rd_data = 0;
  logic rd_req, wr_req, busy, done, es_sbe, es_dbe, es_ecx, es_vld, irq;
  logic [AW-1:0] rd_addr, wr_addr, cur_src, cur_dst;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] cur_cnt;
  logic [NCH-1:0] err_bits;
  logic [CHW-1:0] es_chan;

  dma_term_ctrl #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .count_i(count),
    .src_i(src), .dst_i(dst), .cancel_i(cancel), .ecancel_i(ecancel), .es_clr_i(es_clr),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_err_i(rd_err),
    .rd_data_i(rd_data), .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_ack_i(wr_ack), .wr_err_i(wr_err), .cur_src_o(cur_src), .cur_dst_o(cur_dst),
    .cur_cnt_o(cur_cnt), .busy_o(busy), .done_o(done), .err_bits_o(err_bits),
    .es_chan_o(es_chan), .es_sbe_o(es_sbe), .es_dbe_o(es_dbe), .es_ecx_o(es_ecx),
    .es_vld_o(es_vld), .err_irq_o(irq));

  always #10 clk = ~clk;

  int checks = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model; states 0 idle 1 read 2 write 3 done 4 halted
  int m_st = 0, m_cnt = 0;
  logic [AW-1:0] m_src = 0, m_dst = 0;
  logic [DW-1:0] m_data = 0;
  int m_chan = 0;
  bit m_sbe, m_dbe, m_cx, m_ecx, m_trail;
  bit e_vld, e_sbe, e_dbe, e_ecx;
  int e_chan = 0;
  logic [NCH-1:0] m_bits = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_src = 0; m_dst = 0; m_data = 0; m_chan = 0;
      m_sbe = 0; m_dbe = 0; m_cx = 0; m_ecx = 0; m_trail = 0;
      e_vld = 0; e_sbe = 0; e_dbe = 0; e_ecx = 0; e_chan = 0; m_bits = 0;
    end else begin
      bit halt, h_ecx, stop_cx;
      halt = 0; h_ecx = 0;
      if (m_st == 1 || m_st == 2) begin
        if (m_cnt > 1) begin
          stop_cx = cancel; m_cx = m_cx | stop_cx;
          stop_cx = ecancel; m_ecx = m_ecx | stop_cx;
        end
      end
      if (m_st == 1 && rd_ack) begin
        m_src += 4; m_data = rd_data;
        if (rd_err) m_sbe = 1;
        if (m_trail) halt = 1; else m_st = 2;
      end else if (m_st == 2 && wr_ack) begin
        m_dst += 4; m_cnt -= 1;
        if (m_sbe || wr_err) begin
          if (wr_err && !m_sbe && m_cnt > 0) begin m_trail = 1; m_st = 1; end
          else halt = 1;
          if (wr_err) m_dbe = 1;
        end else if (m_cnt == 0) m_st = 3;
        else if (m_ecx) begin halt = 1; h_ecx = 1; end
        else if (m_cx) m_st = 0;
        else m_st = 1;
      end else if ((m_st == 0 || m_st == 3 || m_st == 4) && start && count != 0) begin
        m_st = 1; m_cnt = count; m_src = src; m_dst = dst; m_data = 0; m_chan = chan;
        m_sbe = 0; m_dbe = 0; m_cx = 0; m_ecx = 0; m_trail = 0;
      end
      if (es_clr) m_bits = 0;
      if (halt) begin
        m_st = 4; e_vld = 1; e_chan = m_chan; e_ecx = h_ecx;
        e_sbe = h_ecx ? 0 : m_sbe; e_dbe = h_ecx ? 0 : m_dbe;
        m_bits[m_chan] = 1'b1;
      end else if (es_clr) e_vld = 0;
    end
  end

  // bus responder and per-cycle comparison
  int lat = 0, rcnt = 0, wcnt = 0, rd_idx = 0, wr_idx = 0, err_rd_at = -1, err_wr_at = -1;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "rd_req", rd_req, m_st == 1);
      chk("R2", "wr_req", wr_req, m_st == 2);
      chk("R2", "rd_addr", rd_addr, m_src);
      chk("R2", "wr_addr", wr_addr, m_dst);
      if (m_st == 2) chk("R3", "wr_data", wr_data, m_data);
      chk("R2", "done", done, m_st == 3);
      chk("R2", "busy", busy, m_st == 1 || m_st == 2);
      chk("R5", "cur_src", cur_src, m_src);
      chk("R5", "cur_dst", cur_dst, m_dst);
      chk("R5", "cur_cnt", cur_cnt, m_cnt[CW-1:0]);
      chk("R9", "es_vld", es_vld, e_vld);
      chk("R9", "err_bits", err_bits, m_bits);
      chk("R8", "irq", irq, e_vld);
      if (e_vld) begin
        chk("R9", "es_chan", es_chan, e_chan[CHW-1:0]);
        chk("R9", "es_sbe", es_sbe, e_sbe);
        chk("R9", "es_dbe", es_dbe, e_dbe);
        chk("R9", "es_ecx", es_ecx, e_ecx);
      end
    end
    rd_ack = 0; rd_err = 0; wr_ack = 0; wr_err = 0;
    if (rd_req) begin
      if (rcnt == lat) begin
        rd_ack = 1; rd_err = (rd_idx == err_rd_at);
        rd_data = 32'h1357_0000 + 32'(rd_idx * 32'h111);
        rd_idx++; rcnt = 0;
      end else rcnt++;
    end else rcnt = 0;
    if (wr_req) begin
      if (wcnt == lat) begin
        wr_ack = 1; wr_err = (wr_idx == err_wr_at);
        wr_idx++; wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  // poke: 0 none, 1 cancel, 2 error cancel, 3 extra start; fired while reading at count poke_cnt
  task automatic run(input int n, input int ch, input int l, input int erd, input int ewr,
                     input int poke, input int poke_cnt);
    bit sent;
    sent = 0;
    @(negedge clk);
    lat = l; err_rd_at = erd; err_wr_at = ewr; rd_idx = 0; wr_idx = 0;
    count = CW'(n); chan = CHW'(ch); src = 32'h0000_1000; dst = 32'h0000_8000;
    start = 1;
    @(negedge clk);
    start = 0;
    while (busy) begin
      @(negedge clk);
      cancel = 0; ecancel = 0; start = 0;
      if (!sent && poke != 0 && rd_req && cur_cnt == CW'(poke_cnt)) begin
        sent = 1;
        if (poke == 1) cancel = 1;
        else if (poke == 2) ecancel = 1;
        else begin start = 1; count = 9; src = 32'h5000; dst = 32'h6000; end
      end
    end
    cancel = 0; ecancel = 0; start = 0;
    @(negedge clk);
  endtask

  task automatic expect_end(input string tag, input int cnt, input int sa, input int da, input bit d);
    chk(tag, "final cnt", cur_cnt, CW'(cnt));
    chk(tag, "final src", cur_src, 32'h1000 + 32'(sa));
    chk(tag, "final dst", cur_dst, 32'h8000 + 32'(da));
    chk(tag, "final done", done, d);
  endtask

  task automatic clear_es();
    @(negedge clk); es_clr = 1;
    @(negedge clk); es_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rd_req", rd_req, 0);
    chk("R1", "wr_req", wr_req, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "es_vld", es_vld, 0);
    chk("R1", "err_bits", err_bits, 0);
    chk("R1", "irq", irq, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(3, 2, 0, -1, -1, 0, 0);
    expect_end("R2", 0, 12, 12, 1);
    run(4, 5, 2, -1, -1, 0, 0);
    expect_end("R2", 0, 16, 16, 1);
    chk("R2", "no error", es_vld, 0);

    run(4, 3, 1, 1, -1, 0, 0);   // read error on second read
    expect_end("R3", 2, 8, 8, 0);
    chk("R3", "sbe", es_sbe, 1);
    chk("R3", "dbe", es_dbe, 0);
    chk("R9", "chan", es_chan, 3);
    chk("R9", "bit", err_bits, 16'h0008);
    chk("R9", "irq", irq, 1);

    clear_es();
    chk("R10", "vld cleared", es_vld, 0);
    chk("R10", "bits cleared", err_bits, 0);
    chk("R10", "chan held", es_chan, 3);

    run(3, 7, 0, -1, 0, 0, 0);   // write error with iterations left
    expect_end("R4", 2, 8, 4, 0);
    chk("R4", "dbe", es_dbe, 1);
    chk("R4", "sbe", es_sbe, 0);
    repeat (3) @(negedge clk);
    chk("R10", "vld held", es_vld, 1);
    clear_es();

    run(2, 1, 1, -1, 1, 0, 0);   // write error on final write
    expect_end("R4", 0, 8, 8, 0);
    chk("R4", "dbe last", es_dbe, 1);
    clear_es();

    run(5, 4, 1, -1, -1, 1, 4);  // cancel during second pair
    expect_end("R6", 3, 8, 8, 0);
    chk("R6", "no status", es_vld, 0);

    run(2, 4, 0, -1, -1, 1, 1);  // cancel on final pair
    expect_end("R7", 0, 8, 8, 1);
    chk("R7", "no status", es_vld, 0);

    run(4, 9, 1, -1, -1, 2, 3);  // error cancel during second pair
    expect_end("R8", 2, 8, 8, 0);
    chk("R8", "ecx", es_ecx, 1);
    chk("R8", "chan", es_chan, 9);
    chk("R8", "sbe clear", es_sbe, 0);
    chk("R8", "bit", err_bits, 16'h0200);
    chk("R8", "irq", irq, 1);
    clear_es();

    run(4, 0, 0, -1, -1, 3, 2);  // start while busy
    expect_end("R11", 0, 16, 16, 1);
    @(negedge clk); count = 0; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk("R11", "zero start busy", busy, 0);
    chk("R11", "zero start done", done, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule